// File: doc/BRIEF.md
# Descending Round-Robin Unit Selector

This block chooses which member of a group of identical execution units the next instruction uses. The group is given as a one-hot-per-unit membership mask. Bit i stands for unit i. The block keeps a rotation mask that holds the units not yet used in the current round. Its output names the highest unit still in that mask, so units are handed out from the top bit down. When every member has been used, the round starts again.

Some instructions are bound to one particular unit and need no dynamic choice. The block accepts such a fixed use and takes that unit out of the current round. A fixed use can name a unit whose bit is already clear. In that case the unit is noted as pending, and it is left out of the next round when the mask reloads. The membership mask is meant to stay constant; it is sampled while reset is asserted. Checking whether the chosen unit is actually free is left to the surrounding logic.

Top module: `descending_rr_selector`

## Requirements
- R1: While reset is asserted and after it is released, the rotation mask equals the group mask and no unit is pending, so `pick_onehot_o` names the highest member unit.
- R2: `pick_onehot_o` is combinational from the rotation mask. It is one-hot with bit i meaning unit i, it names the highest set bit, and it is zero only when the group mask is zero.
- R3: On a clock edge with `pick_req_i` high, the unit shown on `pick_onehot_o` is cleared from the rotation mask.
- R4: When the rotation mask would become empty, it reloads in the same edge with the group mask minus every pending unit.
- R5: On an edge with `fixed_use_i` high, a member unit in `fixed_unit_i` whose rotation bit is set is cleared from the rotation mask. If that empties the mask, the reload of R4 applies.
- R6: A fixed use of a member unit whose rotation bit is already clear leaves the rotation mask unchanged and marks that unit as pending.
- R7: Each reload clears the whole pending set, so a pending unit is skipped for exactly one round.
- R8: When `pick_req_i` and `fixed_use_i` are both high in one cycle, the pick is applied first and the fixed use then acts on the result.
- R9: A fixed use naming a unit outside the group mask changes neither the rotation mask nor the pending set.
- R10: With neither strobe high, the rotation mask and the pending set hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| group_mask_i | input | N_UNITS | Membership mask of the group, held constant |
| pick_req_i | input | 1 | Take the shown unit and advance the rotation |
| pick_onehot_o | output | N_UNITS | One-hot unit chosen for the next pick |
| fixed_use_i | input | 1 | A statically bound unit is being used |
| fixed_unit_i | input | N_UNITS | One-hot unit of the fixed use |

## Verification
The bench runs a full group through plain pick rounds to show the high-to-low order and the reload. It then mixes in fixed uses of bits that are still set and of bits already cleared. The two kinds of fixed use are told apart because the first shortens the current round while the second shortens only the next one. A later plain round shows that the pending unit comes back. One vector applies a pick and a fixed use of that same unit together; the two possible orderings leave different units on the output, which confirms R8. A sparse group mask, an empty group, a non-member fixed use and a mid-run reset cover the remaining boundaries.

// File: rtl/rr_sel_pkg.sv
package rr_sel_pkg;
  // Default group width; bit i of every mask stands for unit i.
  localparam int unsigned RR_DEF_UNITS = 4;

  // Reload value: full group minus the units deferred in the round just ended.
  function automatic logic [RR_DEF_UNITS-1:0] rr_reload_def(
    input logic [RR_DEF_UNITS-1:0] grp,
    input logic [RR_DEF_UNITS-1:0] pend
  );
    return grp & ~pend;
  endfunction
endpackage

// File: rtl/rr_top_pick.sv
// Highest-set-bit finder built as a ripple of "anything above" flags.
module rr_top_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] top_o
);
  logic [N:0] above;

  assign above[N] = 1'b0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_bit
    assign above[i] = above[i+1] | vec_i[i];
    assign top_o[i] = vec_i[i] & ~above[i+1];
  end
endmodule

// File: rtl/rr_mask_step.sv
// One removal step on the rotation state: clear a set bit (reloading when
// empty) or remember an already-cleared bit as pending.
module rr_mask_step #(
  parameter int unsigned N = 4
) (
  input  logic         en_i,
  input  logic [N-1:0] unit_i,
  input  logic [N-1:0] grp_i,
  input  logic [N-1:0] rot_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] rot_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] unit_in_grp;
  logic [N-1:0] rot_cleared;
  logic         is_member;
  logic         still_set;

  assign unit_in_grp = unit_i & grp_i;
  assign is_member   = |unit_in_grp;
  assign still_set   = |(rot_i & unit_in_grp);
  assign rot_cleared = rot_i & ~unit_in_grp;

  always_comb begin
    rot_o  = rot_i;
    pend_o = pend_i;
    if (en_i && is_member) begin
      if (still_set) begin
        if (rot_cleared == '0) begin
          rot_o  = grp_i & ~pend_i;
          pend_o = '0;
        end else begin
          rot_o  = rot_cleared;
        end
      end else begin
        pend_o = pend_i | unit_in_grp;
      end
    end
  end
endmodule

// File: rtl/descending_rr_selector.sv
module descending_rr_selector #(
  parameter int unsigned N_UNITS = rr_sel_pkg::RR_DEF_UNITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] group_mask_i,
  input  logic               pick_req_i,
  output logic [N_UNITS-1:0] pick_onehot_o,
  input  logic               fixed_use_i,
  input  logic [N_UNITS-1:0] fixed_unit_i
);
  localparam int unsigned STAGES = 2;

  logic [N_UNITS-1:0] rot_q,  rot_d;
  logic [N_UNITS-1:0] defer_q, defer_d;
  logic               state_en;

  // Stage chain: stage 0 is the dynamic pick, stage 1 the fixed use (R8).
  logic [N_UNITS-1:0] rot_s  [STAGES+1];
  logic [N_UNITS-1:0] pend_s [STAGES+1];
  logic [N_UNITS-1:0] st_unit [STAGES];
  logic               st_en   [STAGES];

  rr_top_pick #(.N(N_UNITS)) u_pick (
    .vec_i (rot_q),
    .top_o (pick_onehot_o)
  );

  assign st_en[0]   = pick_req_i;
  assign st_unit[0] = pick_onehot_o;
  assign st_en[1]   = fixed_use_i;
  assign st_unit[1] = fixed_unit_i;

  assign rot_s[0]  = rot_q;
  assign pend_s[0] = defer_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    rr_mask_step #(.N(N_UNITS)) u_step (
      .en_i   (st_en[s]),
      .unit_i (st_unit[s]),
      .grp_i  (group_mask_i),
      .rot_i  (rot_s[s]),
      .pend_i (pend_s[s]),
      .rot_o  (rot_s[s+1]),
      .pend_o (pend_s[s+1])
    );
  end

  assign state_en = pick_req_i | fixed_use_i;

  always_comb begin
    rot_d   = rot_s[STAGES];
    defer_d = pend_s[STAGES];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q   <= group_mask_i;
      defer_q <= '0;
    end else if (state_en) begin
      rot_q   <= rot_d;
      defer_q <= defer_d;
    end
  end
endmodule

// File: rtl/rr_sel_checker.sv
module rr_sel_checker #(
  parameter int unsigned N_UNITS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_UNITS-1:0] group_mask_i,
  input logic               pick_req_i,
  input logic [N_UNITS-1:0] pick_onehot_o,
  input logic               fixed_use_i,
  input logic [N_UNITS-1:0] fixed_unit_i,
  input logic [N_UNITS-1:0] rot_q,
  input logic [N_UNITS-1:0] defer_q
);
  a_r2_onehot_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_onehot_o) && ((group_mask_i == '0) || (pick_onehot_o != '0)));

  a_r2_pick_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_onehot_o & ~group_mask_i) == '0);

  a_r3_pick_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_req_i && !fixed_use_i && $countones(rot_q) > 1)
      |=> ((rot_q & $past(pick_onehot_o)) == '0) &&
          ($countones(rot_q) == $countones($past(rot_q)) - 1));

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_req_i && !fixed_use_i && $countones(rot_q) == 1)
      |=> (rot_q == (group_mask_i & ~$past(defer_q))) && (defer_q == '0));

  a_r6_defer_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fixed_use_i && !pick_req_i && ((fixed_unit_i & group_mask_i & ~rot_q) != '0))
      |=> $stable(rot_q) && ((defer_q & $past(fixed_unit_i)) != '0));

  a_r6_defer_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_q & defer_q) == '0);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pick_req_i && !fixed_use_i) |=> $stable(rot_q) && $stable(defer_q));
endmodule

bind descending_rr_selector rr_sel_checker #(.N_UNITS(N_UNITS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .group_mask_i  (group_mask_i),
  .pick_req_i    (pick_req_i),
  .pick_onehot_o (pick_onehot_o),
  .fixed_use_i   (fixed_use_i),
  .fixed_unit_i  (fixed_unit_i),
  .rot_q         (rot_q),
  .defer_q       (defer_q)
);

// File: tb/sim_descending_rr_selector.sv
`timescale 1ns/1ps
module sim_descending_rr_selector;
  localparam int unsigned N = 4;
  localparam int NV = 20;

  // {pick, fixed, fixed_unit[3:0], expected pick_onehot_o[3:0], req id[3:0]}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'b0000, 4'b0100, 4'd3},
    {1'b1, 1'b0, 4'b0000, 4'b0010, 4'd2},
    {1'b1, 1'b0, 4'b0000, 4'b0001, 4'd3},
    {1'b1, 1'b0, 4'b0000, 4'b1000, 4'd4},
    {1'b0, 1'b1, 4'b0100, 4'b1000, 4'd5},
    {1'b1, 1'b0, 4'b0000, 4'b0010, 4'd3},
    {1'b0, 1'b1, 4'b1000, 4'b0010, 4'd6},
    {1'b1, 1'b0, 4'b0000, 4'b0001, 4'd3},
    {1'b1, 1'b0, 4'b0000, 4'b0100, 4'd4},
    {1'b1, 1'b0, 4'b0000, 4'b0010, 4'd2},
    {1'b1, 1'b1, 4'b0010, 4'b0001, 4'd8},
    {1'b0, 1'b0, 4'b0000, 4'b0001, 4'd10},
    {1'b1, 1'b0, 4'b0000, 4'b1000, 4'd4},
    {1'b0, 1'b1, 4'b1000, 4'b0100, 4'd5},
    {1'b0, 1'b1, 4'b1000, 4'b0100, 4'd6},
    {1'b1, 1'b0, 4'b0000, 4'b0001, 4'd3},
    {1'b1, 1'b0, 4'b0000, 4'b0100, 4'd4},
    {1'b1, 1'b0, 4'b0000, 4'b0010, 4'd3},
    {1'b1, 1'b0, 4'b0000, 4'b0001, 4'd3},
    {1'b1, 1'b0, 4'b0000, 4'b1000, 4'd7}
  };

  logic         clk;
  logic         rst_n;
  logic [N-1:0] grp;
  logic         pick;
  logic [N-1:0] pick_oh;
  logic         fix;
  logic [N-1:0] fix_unit;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  descending_rr_selector #(.N_UNITS(N)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .group_mask_i  (grp),
    .pick_req_i    (pick),
    .pick_onehot_o (pick_oh),
    .fixed_use_i   (fix),
    .fixed_unit_i  (fix_unit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp);
    n_checks++;
    if (pick_oh !== exp) begin
      n_errors++;
      $display("FAIL %s: pick_onehot_o=%b expected %b", req, pick_oh, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check just after it.
  task automatic step(input logic p, input logic f, input logic [N-1:0] u,
                      input logic [N-1:0] exp, input string req);
    @(negedge clk);
    pick = p; fix = f; fix_unit = u;
    @(posedge clk);
    #2;
    pick = 1'b0; fix = 1'b0; fix_unit = '0;
    check(req, exp);
  endtask

  task automatic do_reset(input logic [N-1:0] g);
    @(negedge clk);
    grp = g; rst_n = 1'b0;
    pick = 1'b0; fix = 1'b0; fix_unit = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; grp = 4'b1111; pick = 1'b0; fix = 1'b0; fix_unit = '0;

    // R1: reset state with a full group
    do_reset(4'b1111);
    #1 check("R1", 4'b1000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4], req_name(VEC[i][3:0]));
    end

    // R1: reset in the middle of a round restores the full rotation
    step(1'b1, 1'b0, 4'b0000, 4'b0100, "R3");
    do_reset(4'b1111);
    #1 check("R1", 4'b1000);

    // Sparse group 1010
    do_reset(4'b1010);
    #1 check("R1", 4'b1000);
    step(1'b1, 1'b0, 4'b0000, 4'b0010, "R2");
    // R9: non-member fixed unit leaves the rotation untouched
    step(1'b0, 1'b1, 4'b0001, 4'b0010, "R9");
    step(1'b0, 1'b1, 4'b0100, 4'b0010, "R9");
    // R4: reload restores only member units
    step(1'b1, 1'b0, 4'b0000, 4'b1000, "R4");
    step(1'b1, 1'b0, 4'b0000, 4'b0010, "R3");
    // R10: idle cycles hold the selection
    step(1'b0, 1'b0, 4'b1000, 4'b0010, "R10");
    // R5: fixed use of the last set bit reloads
    step(1'b0, 1'b1, 4'b0010, 4'b1000, "R5");

    // R2: an empty group yields no selection
    do_reset(4'b0000);
    #1 check("R2", 4'b0000);
    step(1'b1, 1'b0, 4'b0000, 4'b0000, "R2");

    finish_run();
  end
endmodule